// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Mapper

This block translates addresses for a game cartridge. The CPU writes bank numbers into a small set of registers that sit in the upper half of its address space. The block holds those registers. From the CPU address it forms a program ROM address, from the picture-processor (PPU) address it forms a character ROM address, and it drives the A10 line of the console's video RAM to choose the nametable arrangement.

The CPU sees two 16 KiB program windows. The lower one, CPU 0x8000-0xBFFF, can be switched to any bank. The upper one, CPU 0xC000-0xFFFF, is tied to the last bank of the ROM, and the parameter `PRG_BANKS` gives the number of banks. The PPU pattern space is split into four 2 KiB windows, and each window has its own 6-bit bank register. A 2-bit mode picks where VRAM A10 comes from: PPU A10, PPU A11, constant 0 or constant 1.

A write is decoded with the mask 0xF800, so each register answers across a 2 KiB span of mirrors. All outputs are combinational functions of the stored registers and the current addresses. Writes take effect at the rising clock edge on which `cpu_wr` is high.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, all four character bank registers and the program bank register read as 0, and the mirroring mode is 0 (vertical).
- R2: A clocked write with `cpu_wr` high loads character bank register k (k = 0..3) from `cpu_data[5:0]` when `cpu_addr & 0xF800` equals 0x8800 + k*0x1000. Every address in that 2 KiB span hits the same register.
- R3: `chr_addr` = {character bank register selected by `ppu_addr[12:11]`, `ppu_addr[10:0]`}, which is 17 bits.
- R4: A write hitting mask value 0xF800 loads the program bank from `cpu_data[3:0]`. When `cpu_addr[14]` is 0, `prg_addr` = {program bank, `cpu_addr[13:0]`}.
- R5: When `cpu_addr[14]` is 1, `prg_addr` = {PRG_BANKS-1, `cpu_addr[13:0]`}, whatever the program bank register holds.
- R6: `cpu_data[4]` of a program-bank write is kept as a reserved flag. Bits 7..4 of that write have no effect on any output.
- R7: A write hitting mask value 0xE800 loads the mirroring mode from `cpu_data[1:0]`. `vram_a10` is `ppu_addr[10]` for mode 0, `ppu_addr[11]` for mode 1, 0 for mode 2 and 1 for mode 3.
- R8: Writes whose masked address is none of the six register slots change no register. This covers 0x8000, 0x9000, 0xC800, 0xD800 and the addresses below 0x8000.
- R9: When `cpu_wr` is low, no register changes, whatever the address and data.
- R10: A register write changes the outputs from the cycle after the write edge. Address changes act on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge |
| ppu_addr | input | 13 | PPU pattern-space address (A12..A0) |
| prg_addr | output | 18 | Program ROM address |
| chr_addr | output | 17 | Character ROM address |
| vram_a10 | output | 1 | Video RAM A10 select |

## Verification
The case hardest to reach from the ports is a write to a mirror address deep inside a register's 2 KiB span that is then read back through a different PPU or CPU window. A fault in the mask or the index decode only shows when the wrong register is then observed. For this reason the stimulus writes every bank value through a moving mirror offset, and after each write it probes all four character windows, both program windows and all four A10/A11 combinations. The bench keeps its own model of the registers, built from the requirements. Writes to the decoys and writes with the strobe low are followed by the same full probe, so any change to any register is seen at the ports.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int CHR_BANK_W = 6;
    localparam int CHR_WIN_N  = 4;
    localparam int CHR_OFS_W  = 11;
    localparam int PRG_SEL_W  = 4;
    localparam int PRG_OFS_W  = 14;
    localparam int MIR_W      = 2;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mir_mode_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_CHR,
        HIT_PRG,
        HIT_MIR
    } reg_hit_e;

    typedef struct packed {
        logic [CHR_WIN_N-1:0][CHR_BANK_W-1:0] chr;
        logic [PRG_SEL_W-1:0]                 prg;
        logic                                 ext_flag;
        mir_mode_e                            mir;
    } map_regs_t;
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    output map_regs_t   regs
);
    localparam int IDX_W = $clog2(CHR_WIN_N);

    reg_hit_e         hit;
    logic [IDX_W-1:0] chr_idx;
    map_regs_t        regs_q;

    wire unused_bits = &{1'b0, cpu_addr[10:0], cpu_data[7:6]};

    // Decode with the 0xF800 mask: bits 15..11 choose the slot.
    always_comb begin
        chr_idx = cpu_addr[12 +: IDX_W];
        unique case (1'b1)
            (cpu_addr[15:14] == 2'b10) && cpu_addr[11]: hit = HIT_CHR;
            (cpu_addr[15:11] == 5'b11101):              hit = HIT_MIR;
            (cpu_addr[15:11] == 5'b11111):              hit = HIT_PRG;
            default:                                    hit = HIT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cpu_wr) begin
            unique case (hit)
                HIT_CHR: regs_q.chr[chr_idx] <= cpu_data[CHR_BANK_W-1:0];
                HIT_PRG: begin
                    regs_q.prg      <= cpu_data[PRG_SEL_W-1:0];
                    regs_q.ext_flag <= cpu_data[4];
                end
                HIT_MIR: regs_q.mir <= mir_mode_e'(cpu_data[MIR_W-1:0]);
                default: ;
            endcase
        end
    end

    assign regs = regs_q;

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(regs_q));

    p_decoy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && hit == HIT_NONE) |=> $stable(regs_q));

    p_prg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:11] == 5'b11111)
            |=> regs_q.prg == $past(cpu_data[PRG_SEL_W-1:0]));

    p_mir_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:11] == 5'b11101)
            |=> regs_q.mir == $past(cpu_data[MIR_W-1:0]));

    generate
        for (genvar k = 0; k < CHR_WIN_N; k++) begin : g_chr_chk
            p_chr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cpu_wr && cpu_addr[15:14] == 2'b10 && cpu_addr[11]
                    && cpu_addr[13:12] == k[1:0])
                    |=> regs_q.chr[k] == $past(cpu_data[CHR_BANK_W-1:0]));
        end
    endgenerate
endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PRG_OFS_W:0]             cpu_addr,
    input  logic [PRG_SEL_W-1:0]           prg_bank,
    output logic [PRG_SEL_W+PRG_OFS_W-1:0] prg_addr
);
    localparam logic [PRG_SEL_W-1:0] LAST_BANK = PRG_SEL_W'(PRG_BANKS - 1);

    logic [PRG_SEL_W-1:0] bank_sel;

    always_comb begin
        bank_sel = cpu_addr[PRG_OFS_W] ? LAST_BANK : prg_bank;
        prg_addr = {bank_sel, cpu_addr[PRG_OFS_W-1:0]};
    end

    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[PRG_OFS_W] |-> prg_addr[PRG_SEL_W+PRG_OFS_W-1:PRG_OFS_W] == LAST_BANK);

    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[PRG_OFS_W-1:0] == cpu_addr[PRG_OFS_W-1:0]);
endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
    import mapper_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [12:0]                          ppu_addr,
    input  logic [CHR_WIN_N-1:0][CHR_BANK_W-1:0] chr_banks,
    output logic [CHR_BANK_W+CHR_OFS_W-1:0]      chr_addr
);
    always_comb begin
        chr_addr = {chr_banks[ppu_addr[12:11]], ppu_addr[CHR_OFS_W-1:0]};
    end

    p_chr_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[CHR_OFS_W-1:0] == ppu_addr[CHR_OFS_W-1:0]);
endmodule

// File: rtl/mapper_mirror.sv
module mapper_mirror
    import mapper_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ppu_a10,
    input  logic      ppu_a11,
    input  mir_mode_e mode,
    output logic      vram_a10
);
    always_comb begin
        unique case (mode)
            MIR_VERT:   vram_a10 = ppu_a10;
            MIR_HORZ:   vram_a10 = ppu_a11;
            MIR_ONE_LO: vram_a10 = 1'b0;
            MIR_ONE_HI: vram_a10 = 1'b1;
            default:    vram_a10 = ppu_a10;
        endcase
    end

    p_one_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MIR_ONE_HI) |-> vram_a10);

    p_one_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MIR_ONE_LO) |-> !vram_a10);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    input  logic [12:0] ppu_addr,
    output logic [17:0] prg_addr,
    output logic [16:0] chr_addr,
    output logic        vram_a10
);
    map_regs_t regs;

    wire unused_top = &{1'b0, regs.ext_flag};

    mapper_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .regs     (regs)
    );

    mapper_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr[PRG_OFS_W:0]),
        .prg_bank (regs.prg),
        .prg_addr (prg_addr)
    );

    mapper_chr_xlate u_chr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ppu_addr  (ppu_addr),
        .chr_banks (regs.chr),
        .chr_addr  (chr_addr)
    );

    mapper_mirror u_mir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ppu_a10  (ppu_addr[10]),
        .ppu_a11  (ppu_addr[11]),
        .mode     (regs.mir),
        .vram_a10 (vram_a10)
    );

    p_reset_vals_r1: assert property (@(posedge clk)
        !rst_n |=> (regs.prg == '0 && regs.mir == MIR_VERT && regs.chr == '0));
endmodule

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;
    localparam int PRG_BANKS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [17:0] prg_addr;
    logic [16:0] chr_addr;
    logic        vram_a10;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [5:0] m_chr [4];
    logic [3:0] m_prg;
    logic [1:0] m_mir;

    always #2.5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(PRG_BANKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .vram_a10(vram_a10)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of the register slots, written straight from R2, R4, R6, R7, R8.
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15:14] == 2'b10 && a[11]) m_chr[a[13:12]] = d[5:0];
        else if (a[15:11] == 5'b11111) m_prg = d[3:0];
        else if (a[15:11] == 5'b11101) m_mir = d[1:0];
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    // Probe every window and A10/A11 combination; names the requirement.
    task automatic probe_all(input string req, input logic [10:0] ofs);
        for (int w = 0; w < 4; w++) begin
            ppu_addr = {w[1:0], ofs};
            #1;
            check({req, "/R3 chr"}, 32'(chr_addr), 32'({m_chr[w], ofs}));
            case (m_mir)
                2'd0: check({req, "/R7 a10"}, 32'(vram_a10), 32'(ppu_addr[10]));
                2'd1: check({req, "/R7 a10"}, 32'(vram_a10), 32'(ppu_addr[11]));
                2'd2: check({req, "/R7 a10"}, 32'(vram_a10), 32'd0);
                default: check({req, "/R7 a10"}, 32'(vram_a10), 32'd1);
            endcase
        end
        cpu_addr = {2'b10, ofs, 3'b101};
        #1;
        check({req, "/R4 prg lo"}, 32'(prg_addr), 32'({m_prg, cpu_addr[13:0]}));
        cpu_addr = {2'b11, ofs, 3'b010};
        #1;
        check({req, "/R5 prg hi"}, 32'(prg_addr), 32'({4'(PRG_BANKS - 1), cpu_addr[13:0]}));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) m_chr[k] = '0;
        m_prg = '0;
        m_mir = '0;
        // dirty the registers before reset so R1 is meaningful
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cpu_write(16'hF800, 8'h05);
        cpu_write(16'h9800, 8'h2A);
        cpu_write(16'hE800, 8'h03);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) m_chr[k] = '0;
        m_prg = '0;
        m_mir = '0;
        // R1: reset state
        probe_all("R1", 11'h400);
        probe_all("R1", 11'h0FF);

        // R2/R3: every bank value into every window via a moving mirror offset
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 64; v++) begin
                logic [15:0] a;
                a = 16'h8800 + 16'(k * 16'h1000) + 16'((v * 37) & 16'h7FF);
                cpu_write(a, {2'(v), 6'(v)});
                probe_all("R2", 11'((v * 91) & 11'h7FF));
            end
        end

        // R4/R5/R6: all data values into the program bank slot
        for (int v = 0; v < 256; v++) begin
            cpu_write(16'hF800 | 16'((v * 13) & 16'h7FF), 8'(v));
            probe_all("R6", 11'((v * 29) & 11'h7FF));
        end

        // R7: each mirroring mode across A10/A11 combinations
        for (int m = 0; m < 8; m++) begin
            cpu_write(16'hE800 | 16'(m * 16'h0F1), {6'(m * 5), 2'(m)});
            for (int c = 0; c < 4; c++) probe_all("R7", {c[1:0], 9'h033});
        end

        // R8: decoy slots and unmapped space
        cpu_write(16'hF800, 8'h03);
        cpu_write(16'hE800, 8'h01);
        begin
            logic [15:0] decoys [8];
            decoys = '{16'h8000, 16'h9000, 16'hA7FF, 16'hC800, 16'hD800,
                       16'hC000, 16'h7800, 16'h0800};
            for (int i = 0; i < 8; i++) begin
                cpu_write(decoys[i], 8'hFF);
                probe_all("R8", 11'h555);
            end
        end

        // R9: strobe low while presenting hitting addresses
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cpu_addr = (i % 2 == 0) ? 16'hB800 : 16'hF800;
            cpu_data = 8'h3C;
            cpu_wr = 1'b0;
            @(negedge clk);
            probe_all("R9", 11'h2AA);
        end

        // R10: write edge timing; output unchanged before the edge, new after
        @(negedge clk);
        ppu_addr = 13'h0800 | 13'h012;
        cpu_addr = 16'h9800; cpu_data = 8'h11; cpu_wr = 1'b1;
        #1;
        check("R10 before edge", 32'(chr_addr), 32'({m_chr[1], 11'h012}));
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(16'h9800, 8'h11);
        #1;
        check("R10 after edge", 32'(chr_addr), 32'({6'h11, 11'h012}));

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule